// File: doc/BRIEF.md
# Filtered tamper input detector

The block guards one external tamper pin. The pin level is brought into the sampling clock domain through a two-flop synchronizer, and a qualifying event on it sets a sticky tamper flag, which also drives an interrupt when the interrupt enable is set. A polarity bit picks the active direction: 0 means a rising edge or a high level, and 1 means a falling edge or a low level.

A 2-bit filter field picks the detection mode. With the field at 0 the block works in edge mode and reacts to the first transition into the active level. Any other value selects filtered level mode. In that mode a free-running divider produces a sample strobe at a selectable rate. Over the last few cycles before each strobe the block turns on the pin pull-up so that the pin is precharged. An event fires once 2, 4 or 8 samples in a row read the active level. A slow sample rate keeps the pull-up on for a smaller share of the time and so saves power, but detection takes longer.

After an event the detector is disarmed. It arms again only when it is disabled and then enabled. When enable rises the previous level counts as inactive, so a pin that is already at the active level fires at once. This gives level-like behaviour when the detector is re-enabled while the tamper condition still holds.

Top module: `tamper_watch`

## Requirements
- R1: After reset, tamper_flag, irq, pullup_en and sample_stb are all 0.
- R2: The pin passes through a two-flop synchronizer. In edge mode the flag is low two clock edges after the pin moves to the active level and high after the third edge.
- R3: filt_sel = 0 selects edge mode. polarity = 0 detects a rising edge and polarity = 1 detects a falling edge.
- R4: In edge mode, if the pin is already at the active level when enable rises, the flag sets at the first enabled clock edge.
- R5: After an event, the detector raises no further event until enable has been low for at least one cycle. Re-enabling while the pin is still active fires again.
- R6: filt_sel values 1, 2 and 3 set the flag after 2, 4 and 8 consecutive samples at the active level. The flag is still low when the strobe for the last of those samples is high, and it is high one cycle later.
- R7: A sample at the inactive level resets the run of consecutive samples to zero, and so does a low enable.
- R8: In level mode, sample_stb pulses for one cycle every 2^(BASE_SHIFT+rate_sel) cycles. The first pulse comes 2^(BASE_SHIFT+rate_sel)-1 cycles after enable rises.
- R9: Unless pullup_off is set, pullup_en is high for the last 2^prech_sel cycles of each sample period, and that window includes the strobe cycle. With pullup_off set, pullup_en stays low and sampling goes on.
- R10: The flag stays set until a flag_clr pulse arrives. If an event and a clear happen in the same cycle, the flag is left set.
- R11: irq is high exactly when tamper_flag and irq_en are both high.
- R12: While enable is low there are no strobes and no pull-up, and pin activity does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 1 | Tamper pin, asynchronous |
| enable | input | 1 | Detector enable; low disarms and re-arms |
| polarity | input | 1 | 0: rising/high active, 1: falling/low active |
| filt_sel | input | 2 | 0: edge mode; 1/2/3: 2/4/8 consecutive samples |
| rate_sel | input | 3 | Sample period 2^(BASE_SHIFT+rate_sel) cycles |
| prech_sel | input | 2 | Precharge length 2^prech_sel cycles |
| pullup_off | input | 1 | Suppresses precharge |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle clear of the tamper flag |
| pullup_en | output | 1 | Pin pull-up request |
| sample_stb | output | 1 | Level sample strobe |
| tamper_flag | output | 1 | Sticky tamper flag |
| irq | output | 1 | Tamper interrupt |

## Verification
The bench sweeps every filter count against every sample rate and both polarities. It checks the position of the first strobe and of each later one, which catches an off-by-one period and a divider that does not restart on enable. A sample at the inactive level is placed in the middle of a run. A counter that only saturates, or that keeps its value across a disable, would then fire early. Edge mode is checked for exact synchronizer latency, for firing when the pin is already active at enable, and for staying silent after a clear until the detector is re-enabled. A design that re-arms on clear would fire a second time there. The precharge window is measured for every length, with the pull-up suppressed and not suppressed, so a window that is shifted or truncated shows up as a wrong high count or a pull-up that is low on the strobe cycle.

// File: rtl/tamper_watch.sv
`timescale 1ns/1ps
module tamper_watch #(
  parameter int BASE_SHIFT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_raw,
  input  logic       enable,
  input  logic       polarity,
  input  logic [1:0] filt_sel,
  input  logic [2:0] rate_sel,
  input  logic [1:0] prech_sel,
  input  logic       pullup_off,
  input  logic       irq_en,
  input  logic       flag_clr,
  output logic       pullup_en,
  output logic       sample_stb,
  output logic       tamper_flag,
  output logic       irq
);
  localparam int CW = BASE_SHIFT + 7;

  logic          s1, s2;
  logic          act, act_prev, armed;
  logic [CW-1:0] cnt;
  logic [CW:0]   per_m1, pre_n, cnt_x;
  logic [3:0]    hits, need;
  logic          edge_mode, lvl_on, lvl_hit, edge_hit, evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_raw;
      s2 <= s1;
    end

  assign act       = s2 ^ polarity;
  assign edge_mode = (filt_sel == 2'd0);
  assign lvl_on    = enable & ~edge_mode;

  assign per_m1 = ((CW+1)'(1) << (BASE_SHIFT + int'(rate_sel))) - (CW+1)'(1);
  assign pre_n  = (CW+1)'(1) << prech_sel;
  assign cnt_x  = {1'b0, cnt};
  assign need   = 4'd1 << filt_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt <= '0;
    else if (!lvl_on)
      cnt <= '0;
    else if (cnt_x >= per_m1)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;

  assign sample_stb = lvl_on & (cnt_x == per_m1);
  assign pullup_en  = lvl_on & ~pullup_off & ((cnt_x + pre_n) > per_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      hits <= '0;
    else if (!enable)
      hits <= '0;
    else if (sample_stb)
      hits <= act ? ((hits == 4'hF) ? hits : hits + 4'd1) : 4'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      act_prev <= 1'b0;
    else
      act_prev <= enable & act;

  assign lvl_hit  = sample_stb & act & ((hits + 4'd1) == need);
  assign edge_hit = edge_mode & act & ~act_prev;
  assign evt      = enable & armed & (edge_mode ? edge_hit : lvl_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      armed <= 1'b1;
    else if (!enable)
      armed <= 1'b1;
    else if (evt)
      armed <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      tamper_flag <= 1'b0;
    else if (evt)
      tamper_flag <= 1'b1;
    else if (flag_clr)
      tamper_flag <= 1'b0;

  assign irq = tamper_flag & irq_en;
endmodule

module tamper_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic pullup_off,
  input logic flag_clr,
  input logic pullup_en,
  input logic sample_stb,
  input logic tamper_flag,
  input logic [1:0] filt_sel
);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tamper_flag && !flag_clr) |=> tamper_flag);
  p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !enable) |=> !tamper_flag);
  p_no_pull_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_off |-> !pullup_en);
  p_pull_at_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !pullup_off) |-> pullup_en);
  p_quiet_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!pullup_en && !sample_stb));
  p_stb_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (filt_sel != 2'd0));
  p_stb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
endmodule

bind tamper_watch tamper_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pullup_off(pullup_off),
  .flag_clr(flag_clr), .pullup_en(pullup_en), .sample_stb(sample_stb),
  .tamper_flag(tamper_flag), .filt_sel(filt_sel)
);

// File: tb/tamper_watch_tb.sv
`timescale 1ns/1ps
module tamper_watch_tb;
  localparam int BS = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_raw = 1'b0, enable = 1'b0, polarity = 1'b0;
  logic [1:0] filt_sel = 2'd0, prech_sel = 2'd0;
  logic [2:0] rate_sel = 3'd0;
  logic pullup_off = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic pullup_en, sample_stb, tamper_flag, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tamper_watch #(.BASE_SHIFT(BS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .enable(enable),
    .polarity(polarity), .filt_sel(filt_sel), .rate_sel(rate_sel),
    .prech_sel(prech_sel), .pullup_off(pullup_off), .irq_en(irq_en),
    .flag_clr(flag_clr), .pullup_en(pullup_en), .sample_stb(sample_stb),
    .tamper_flag(tamper_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stb();
    int n = 0;
    do begin step(1); n++; end while (!sample_stb && n < 5000);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  task automatic run_level(input int f, input int r, input bit pol);
    int need, per, cyc, seen, last;
    need = 1 << f; per = 1 << (BS + r);
    enable = 0; polarity = pol; pin_raw = pol; filt_sel = 2'(f);
    rate_sel = 3'(r); prech_sel = 0; pullup_off = 0; step(3);
    enable = 1; pin_raw = !pol; cyc = 0; seen = 0; last = 0;
    while (seen < need && cyc < 4 * per * need) begin
      step(1); cyc++;
      if (sample_stb) begin
        seen++;
        chk(cyc - last == ((seen == 1) ? per - 1 : per), "R8 strobe spacing",
            cyc - last, (seen == 1) ? per - 1 : per);
        chk(tamper_flag == 0, "R6 flag before final sample", tamper_flag, 0);
        last = cyc;
      end
    end
    step(1);
    chk(tamper_flag == 1, "R6 flag after final sample", tamper_flag, 1);
    enable = 0; clear_flag();
    chk(tamper_flag == 0, "R10 clear", tamper_flag, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(2);
    chk(!tamper_flag && !irq && !pullup_en && !sample_stb, "R1 reset outputs",
        {tamper_flag, irq, pullup_en, sample_stb}, 0);
    rst_n = 1; step(2);

    for (int pol = 0; pol < 2; pol++) begin
      enable = 0; filt_sel = 0; polarity = 1'(pol); pin_raw = 1'(pol); step(3);
      enable = 1; step(4);
      chk(tamper_flag == 0, "R3 idle edge mode", tamper_flag, 0);
      pin_raw = !1'(pol); step(2);
      chk(tamper_flag == 0, "R2 flag low after two edges", tamper_flag, 0);
      step(1);
      chk(tamper_flag == 1, "R2 R3 flag after third edge", tamper_flag, 1);
      irq_en = 0;
      chk(irq == 0, "R11 irq masked", irq, 0);
      irq_en = 1; step(1);
      chk(irq == 1, "R11 irq raised", irq, 1);
      clear_flag();
      chk(tamper_flag == 0 && irq == 0, "R10 R11 clear", tamper_flag, 0);
      pin_raw = 1'(pol); step(4); pin_raw = !1'(pol); step(5);
      chk(tamper_flag == 0, "R5 no refire while armed off", tamper_flag, 0);
      enable = 0; step(1); enable = 1; step(1);
      chk(tamper_flag == 1, "R4 R5 refire on re-enable while active", tamper_flag, 1);
      enable = 0; clear_flag(); irq_en = 0;
    end

    enable = 0; filt_sel = 0; polarity = 0; pin_raw = 1; step(4);
    enable = 1; step(1);
    chk(tamper_flag == 1, "R4 pin already high at enable", tamper_flag, 1);
    enable = 0; clear_flag();

    pin_raw = 0; step(3); enable = 1; step(2);
    pin_raw = 1; step(2); flag_clr = 1; step(1); flag_clr = 0;
    chk(tamper_flag == 1, "R10 event wins over clear", tamper_flag, 1);
    enable = 0; clear_flag();

    filt_sel = 1; pin_raw = 0;
    for (int i = 0; i < 40; i++) begin
      pin_raw = ~pin_raw; step(1);
      chk(!pullup_en && !sample_stb && !tamper_flag, "R12 disabled quiet",
          {pullup_en, sample_stb, tamper_flag}, 0);
    end

    for (int f = 1; f < 4; f++)
      for (int r = 0; r < 8; r++)
        for (int pol = 0; pol < 2; pol++)
          run_level(f, r, 1'(pol));

    enable = 0; polarity = 0; pin_raw = 0; filt_sel = 2; rate_sel = 0; step(3);
    enable = 1; pin_raw = 1;
    repeat (3) wait_stb();
    pin_raw = 0; wait_stb(); pin_raw = 1;
    repeat (3) wait_stb();
    step(1);
    chk(tamper_flag == 0, "R7 inactive sample resets run", tamper_flag, 0);
    wait_stb(); step(1);
    chk(tamper_flag == 1, "R7 R6 fires after fresh run", tamper_flag, 1);
    enable = 0; clear_flag();

    pin_raw = 1; step(2); enable = 1;
    repeat (3) wait_stb();
    enable = 0; step(2); enable = 1;
    repeat (3) wait_stb();
    step(1);
    chk(tamper_flag == 0, "R7 disable resets run", tamper_flag, 0);
    wait_stb(); step(1);
    chk(tamper_flag == 1, "R7 fires after four new samples", tamper_flag, 1);
    enable = 0; clear_flag();

    pin_raw = 0; filt_sel = 1; rate_sel = 0;
    for (int p = 0; p < 4; p++)
      for (int off = 0; off < 2; off++) begin
        int hi;
        enable = 0; prech_sel = 2'(p); pullup_off = 1'(off); step(2);
        enable = 1; wait_stb();
        hi = 0;
        for (int c = 0; c < (1 << BS); c++) begin
          step(1);
          if (pullup_en) hi++;
        end
        chk(sample_stb == 1, "R8 R9 period with precharge", sample_stb, 1);
        chk(pullup_en == !off, "R9 pull-up on strobe cycle", pullup_en, !off);
        chk(hi == (off ? 0 : (1 << p)), "R9 precharge length", hi, off ? 0 : (1 << p));
      end
    chk(tamper_flag == 0, "R12 inactive pin no event", tamper_flag, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule